// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one integer by another over several clock cycles and returns the quotient and the remainder together. A caller presents a dividend, a divisor and two mode bits on a valid/ready handshake. One mode bit selects two's complement or unsigned operands. The other selects whether a signed quotient is rounded toward zero or toward minus infinity. The divider takes the magnitudes of the operands and forms one quotient bit per cycle, most significant first. At each step it speculatively subtracts the divisor from the shifted partial remainder and keeps the difference only when no borrow occurs. When the loop ends, it restores the signs and, in floored mode, applies the correction.

Two cases have no ordinary answer, and each raises its own flag. The first is a zero divisor. The second is the most negative signed value divided by minus one, whose true quotient does not fit in the operand width. Every operation takes the same number of cycles, whatever the operand values. A single-cycle completion pulse marks the moment the results become valid. The results then stay unchanged until the next operation completes.

Top module: `div_unit`

## Requirements
- R1: `start_ready` is high whenever no operation is in progress. An operation is accepted on a rising clock edge where `start_valid` and `start_ready` are both high. `start_ready` is low in the cycle after acceptance.
- R2: `done` is high for exactly one cycle. That cycle is the one following the rising edge WIDTH+1 edges after the accepting edge.
- R3: In unsigned mode (`signed_mode`=0), `quotient` and `remainder` are the unsigned truncated quotient and remainder. The remainder is smaller than the divisor, so 13 ÷ 3 gives 4 remainder 1.
- R4: In signed mode (`signed_mode`=1, `floor_mode`=0), operands are two's complement. The quotient is rounded toward zero and is negative exactly when one operand is negative. The remainder carries the sign of the dividend, so -17 ÷ 5 gives -3 remainder -2.
- R5: With `signed_mode`=1 and `floor_mode`=1, the divider starts from the R4 result. If the operand signs differ and the remainder is non-zero, the quotient is decreased by one and the divisor is added to the remainder, so -17 ÷ 5 gives -4 remainder 3 and 17 ÷ -5 gives -4 remainder -3. In unsigned mode, `floor_mode` has no effect.
- R6: For any non-zero divisor, quotient × divisor + remainder equals the dividend modulo 2^WIDTH.
- R7: A zero divisor sets `div_by_zero`, clears `overflow`, gives an all-ones quotient and returns the dividend as the remainder. `done` still pulses with the R2 timing.
- R8: In signed mode, a dividend of 1 followed by zeros (the minimum value) divided by all ones (-1) sets `overflow`. The quotient is then the minimum value and the remainder is 0. In unsigned mode the same bit patterns give an ordinary result with no flag.
- R9: `start_valid` has no effect while an operation is in progress. It starts no second operation, produces no extra `done`, and leaves the pending result unchanged.
- R10: `quotient`, `remainder`, `div_by_zero` and `overflow` change only in a cycle where `done` is high.
- R11: Reset (`rst_n` low) clears all outputs and `done`, and leaves `start_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_valid | input | 1 | Request to begin a division |
| start_ready | output | 1 | Divider idle and able to accept |
| dividend | input | WIDTH | Dividend operand |
| divisor | input | WIDTH | Divisor operand |
| signed_mode | input | 1 | 1: two's complement operands; 0: unsigned |
| floor_mode | input | 1 | 1: floored rounding of signed quotients; 0: toward zero |
| done | output | 1 | One-cycle pulse: results valid |
| quotient | output | WIDTH | Quotient result |
| remainder | output | WIDTH | Remainder result |
| div_by_zero | output | 1 | Divisor was zero |
| overflow | output | 1 | Signed minimum value divided by -1 |

## Verification
The operands are captured on the accepting edge. The WIDTH following edges each retire one quotient bit, and one more edge registers the signed and corrected result. So all four result outputs and `done` appear together, WIDTH+1 edges after acceptance, whatever the operand values or flags. For every accepted request, the driver records the cycle number of the accepting edge together with the independently computed results. The monitor samples on falling edges and requires each `done` to arrive exactly WIDTH+1 cycles after the matching entry. A `done` with no queued entry counts as a failure. The idle-interval checks sample the held outputs several cycles after `done` and before any new acceptance.

// File: rtl/div_pkg.sv
package div_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } div_state_e;

   typedef struct packed {
      logic signed_op;
      logic floor_op;
      logic q_neg;
      logic r_neg;
      logic by_zero;
      logic ovf;
   } div_ctl_t;

endpackage

// File: rtl/div_prep.sv
module div_prep
   import div_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] dvd_in,
   input  logic [WIDTH-1:0] dvs_in,
   input  logic             signed_in,
   input  logic             floor_in,
   output logic [WIDTH-1:0] dvd_mag,
   output logic [WIDTH-1:0] dvs_mag,
   output div_ctl_t         ctl
);

   localparam logic [WIDTH-1:0] MIN_VAL = {1'b1, {(WIDTH-1){1'b0}}};

   logic a_neg;
   logic b_neg;

   always_comb begin
      a_neg       = signed_in & dvd_in[WIDTH-1];
      b_neg       = signed_in & dvs_in[WIDTH-1];
      dvd_mag     = a_neg ? (~dvd_in + 1'b1) : dvd_in;
      dvs_mag     = b_neg ? (~dvs_in + 1'b1) : dvs_in;
      ctl.signed_op = signed_in;
      ctl.floor_op  = floor_in;
      ctl.q_neg     = a_neg ^ b_neg;
      ctl.r_neg     = a_neg;
      ctl.by_zero   = (dvs_in == '0);
      ctl.ovf       = signed_in & (dvd_in == MIN_VAL) & (dvs_in == '1);
   end

endmodule

// File: rtl/div_iter.sv
module div_iter #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [WIDTH-1:0] dvd_mag,
   input  logic [WIDTH-1:0] dvs_mag,
   output logic [WIDTH-1:0] q_mag,
   output logic [WIDTH-1:0] r_mag
);

   localparam int SW = WIDTH + 1;
   localparam int DW = WIDTH + 2;

   logic [WIDTH-1:0] rem_q;
   logic [WIDTH-1:0] quo_q;
   logic [WIDTH-1:0] dvs_q;
   logic [SW-1:0]    shifted;
   logic [DW-1:0]    trial;
   logic             fits;
   logic [WIDTH-1:0] rem_nxt;
   logic [WIDTH-1:0] quo_nxt;

   always_comb begin
      shifted = {rem_q, quo_q[WIDTH-1]};
      trial   = {1'b0, shifted} - {2'b00, dvs_q};
      fits    = ~trial[DW-1];
      rem_nxt = fits ? trial[WIDTH-1:0] : shifted[WIDTH-1:0];
      quo_nxt = {quo_q[WIDTH-2:0], fits};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         quo_q <= '0;
         dvs_q <= '0;
      end else if (load) begin
         rem_q <= '0;
         quo_q <= dvd_mag;
         dvs_q <= dvs_mag;
      end else if (step) begin
         rem_q <= rem_nxt;
         quo_q <= quo_nxt;
      end
   end

   assign q_mag = quo_q;
   assign r_mag = rem_q;

   // R3
   rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dvs_q != '0) |-> (rem_q < dvs_q));

endmodule

// File: rtl/div_fixup.sv
module div_fixup
   import div_pkg::*;
#(
   parameter int WIDTH    = 32,
   parameter bit FLOOR_EN = 1'b1
) (
   input  logic [WIDTH-1:0] q_mag,
   input  logic [WIDTH-1:0] r_mag,
   input  logic [WIDTH-1:0] dvd_raw,
   input  logic [WIDTH-1:0] dvs_raw,
   input  div_ctl_t         ctl,
   output logic [WIDTH-1:0] quo,
   output logic [WIDTH-1:0] rem
);

   localparam logic [WIDTH-1:0] MIN_VAL = {1'b1, {(WIDTH-1){1'b0}}};

   logic [WIDTH-1:0] q_s;
   logic [WIDTH-1:0] r_s;
   logic [WIDTH-1:0] q_f;
   logic [WIDTH-1:0] r_f;

   always_comb begin
      q_s = ctl.q_neg ? (~q_mag + 1'b1) : q_mag;
      r_s = ctl.r_neg ? (~r_mag + 1'b1) : r_mag;
   end

   generate
      if (FLOOR_EN) begin : g_floor
         logic adj;
         always_comb begin
            adj = ctl.signed_op & ctl.floor_op & ctl.q_neg & (r_mag != '0);
            q_f = adj ? (q_s - 1'b1) : q_s;
            r_f = adj ? (r_s + dvs_raw) : r_s;
         end
      end else begin : g_trunc
         always_comb begin
            q_f = q_s;
            r_f = r_s;
         end
      end
   endgenerate

   always_comb begin
      if (ctl.by_zero) begin
         quo = '1;
         rem = dvd_raw;
      end else if (ctl.ovf) begin
         quo = MIN_VAL;
         rem = '0;
      end else begin
         quo = q_f;
         rem = r_f;
      end
   end

endmodule

// File: rtl/div_unit.sv
module div_unit
   import div_pkg::*;
#(
   parameter int WIDTH    = 32,
   parameter bit FLOOR_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_valid,
   output logic             start_ready,
   input  logic [WIDTH-1:0] dividend,
   input  logic [WIDTH-1:0] divisor,
   input  logic             signed_mode,
   input  logic             floor_mode,
   output logic             done,
   output logic [WIDTH-1:0] quotient,
   output logic [WIDTH-1:0] remainder,
   output logic             div_by_zero,
   output logic             overflow
);

   localparam int CNT_W = $clog2(WIDTH + 1);
   localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(WIDTH);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

   generate
      if (WIDTH < 2) begin : g_width_chk
         $error("div_unit: WIDTH must be at least 2");
      end
   endgenerate

   div_state_e       state;
   logic [CNT_W-1:0] cnt;
   div_ctl_t         ctl_q;
   logic [WIDTH-1:0] dvd_q;
   logic [WIDTH-1:0] dvs_q;

   logic             accept;
   logic [WIDTH-1:0] dvd_mag;
   logic [WIDTH-1:0] dvs_mag;
   div_ctl_t         ctl_d;
   logic [WIDTH-1:0] q_mag;
   logic [WIDTH-1:0] r_mag;
   logic [WIDTH-1:0] fx_q;
   logic [WIDTH-1:0] fx_r;

   assign start_ready = (state == ST_IDLE);
   assign accept      = start_valid & start_ready;

   div_prep #(.WIDTH(WIDTH)) u_prep (
      .dvd_in    (dividend),
      .dvs_in    (divisor),
      .signed_in (signed_mode),
      .floor_in  (floor_mode),
      .dvd_mag   (dvd_mag),
      .dvs_mag   (dvs_mag),
      .ctl       (ctl_d)
   );

   div_iter #(.WIDTH(WIDTH)) u_iter (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .step    (state == ST_RUN),
      .dvd_mag (dvd_mag),
      .dvs_mag (dvs_mag),
      .q_mag   (q_mag),
      .r_mag   (r_mag)
   );

   div_fixup #(.WIDTH(WIDTH), .FLOOR_EN(FLOOR_EN)) u_fix (
      .q_mag   (q_mag),
      .r_mag   (r_mag),
      .dvd_raw (dvd_q),
      .dvs_raw (dvs_q),
      .ctl     (ctl_q),
      .quo     (fx_q),
      .rem     (fx_r)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         cnt         <= '0;
         ctl_q       <= '0;
         dvd_q       <= '0;
         dvs_q       <= '0;
         done        <= 1'b0;
         quotient    <= '0;
         remainder   <= '0;
         div_by_zero <= 1'b0;
         overflow    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  ctl_q <= ctl_d;
                  dvd_q <= dividend;
                  dvs_q <= divisor;
                  cnt   <= CNT_INIT;
                  state <= ST_RUN;
               end
            end
            ST_RUN: begin
               cnt <= cnt - 1'b1;
               if (cnt == CNT_LAST) state <= ST_FIN;
            end
            ST_FIN: begin
               quotient    <= fx_q;
               remainder   <= fx_r;
               div_by_zero <= ctl_q.by_zero;
               overflow    <= ctl_q.ovf;
               done        <= 1'b1;
               state       <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R1
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_valid && start_ready) |=> !start_ready);

   // R2
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && cnt == CNT_LAST) |-> ##2 done);

   // R7
   dz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && div_by_zero) |-> (quotient == '1 && !overflow));

   // R8
   ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && overflow) |-> (remainder == '0));

   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(quotient) && $stable(remainder) &&
                 $stable(div_by_zero) && $stable(overflow)));

endmodule

// File: tb/div_unit_tb.sv
module div_unit_tb;

   localparam int W = 32;

   typedef struct {
      logic [W-1:0] a;
      logic [W-1:0] b;
      logic [W-1:0] q;
      logic [W-1:0] r;
      bit           dz;
      bit           ovf;
      int           acc;
      string        tag;
   } item_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_valid = 1'b0;
   logic         start_ready;
   logic [W-1:0] dividend = '0;
   logic [W-1:0] divisor = '0;
   logic         signed_mode = 1'b0;
   logic         floor_mode = 1'b0;
   logic         done;
   logic [W-1:0] quotient;
   logic [W-1:0] remainder;
   logic         div_by_zero;
   logic         overflow;

   int    cyc = 0;
   int    n_chk = 0;
   int    n_fail = 0;
   item_t sb[$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   div_unit #(.WIDTH(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
      .dividend(dividend), .divisor(divisor), .signed_mode(signed_mode),
      .floor_mode(floor_mode), .done(done), .quotient(quotient), .remainder(remainder),
      .div_by_zero(div_by_zero), .overflow(overflow)
   );

   task automatic check(input bit ok, input string what, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   function automatic item_t model(input logic [W-1:0] a, input logic [W-1:0] b,
                                   input bit sm, input bit fm, input string tag);
      item_t  it;
      longint sa, sb_, qq, rr;
      it.a = a; it.b = b; it.tag = tag; it.dz = 0; it.ovf = 0; it.acc = 0;
      if (b == '0) begin
         it.dz = 1; it.q = '1; it.r = a;
      end else if (sm && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
         it.ovf = 1; it.q = 32'h8000_0000; it.r = '0;
      end else if (sm) begin
         sa = longint'($signed(a));
         sb_ = longint'($signed(b));
         qq = sa / sb_;
         rr = sa % sb_;
         if (fm && rr != 0 && ((rr < 0) != (sb_ < 0))) begin
            qq = qq - 1;
            rr = rr + sb_;
         end
         it.q = qq[W-1:0];
         it.r = rr[W-1:0];
      end else begin
         it.q = a / b;
         it.r = a % b;
      end
      return it;
   endfunction

   task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit sm, input bit fm, input string tag);
      item_t it;
      @(negedge clk);
      while (!start_ready) @(negedge clk);
      it = model(a, b, sm, fm, tag);
      it.acc = cyc + 1;
      sb.push_back(it);
      dividend = a; divisor = b; signed_mode = sm; floor_mode = fm;
      start_valid = 1'b1;
      @(negedge clk);
      start_valid = 1'b0;
   endtask

   task automatic drain();
      while (sb.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sb.size() == 0) begin
            check(0, "R9 done with no pending request", '0, '0);
         end else begin
            item_t e;
            logic [W-1:0] prod;
            e = sb.pop_front();
            check(cyc == e.acc + W + 1, {e.tag, " R2 latency"}, W'(cyc), W'(e.acc + W + 1));
            check(quotient == e.q, {e.tag, " quotient"}, quotient, e.q);
            check(remainder == e.r, {e.tag, " remainder"}, remainder, e.r);
            check(div_by_zero == e.dz, {e.tag, " R7 div_by_zero flag"}, W'(div_by_zero), W'(e.dz));
            check(overflow == e.ovf, {e.tag, " R8 overflow flag"}, W'(overflow), W'(e.ovf));
            if (e.b != '0) begin
               prod = quotient * e.b + remainder;
               check(prod == e.a, {e.tag, " R6 identity"}, prod, e.a);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      // R11 reset state
      check(start_ready == 1'b1, "R11 ready in reset", W'(start_ready), 1);
      check(done == 1'b0 && quotient == '0 && remainder == '0, "R11 outputs in reset",
            quotient, '0);
      check(!div_by_zero && !overflow, "R11 flags in reset", W'({div_by_zero, overflow}), 0);
      rst_n = 1'b1;

      issue(13, 3, 0, 0, "R3");
      issue(13, 3, 0, 1, "R3 R5");
      issue(32'hFFFF_FFFF, 7, 0, 0, "R3");
      issue(5, 9, 0, 0, "R3");
      issue(-32'sd17, 5, 1, 0, "R4");
      issue(17, -32'sd5, 1, 0, "R4");
      issue(-32'sd17, -32'sd5, 1, 0, "R4");
      issue(-32'sd17, 5, 1, 1, "R5");
      issue(17, -32'sd5, 1, 1, "R5");
      issue(-32'sd15, 5, 1, 1, "R5");
      issue(-32'sd17, -32'sd5, 1, 1, "R5");
      issue(100, 0, 0, 0, "R7");
      issue(-32'sd9, 0, 1, 1, "R7");
      issue(32'h8000_0000, 32'hFFFF_FFFF, 1, 0, "R8");
      issue(32'h8000_0000, 32'hFFFF_FFFF, 1, 1, "R8");
      issue(32'h8000_0000, 32'hFFFF_FFFF, 0, 0, "R8");
      issue(32'h8000_0000, 1, 1, 0, "R4");
      issue(32'h7FFF_FFFF, 32'h8000_0000, 1, 1, "R5");
      issue(0, 12345, 1, 0, "R4");
      drain();

      // R9: start while busy
      issue(100, 7, 0, 0, "R9");
      repeat (4) @(negedge clk);
      check(start_ready == 1'b0, "R1 ready low while busy", W'(start_ready), 0);
      dividend = 999; divisor = 1; start_valid = 1'b1;
      @(negedge clk);
      start_valid = 1'b0;
      drain();
      repeat (40) @(negedge clk);
      // R10 outputs held after done
      check(quotient == 14, "R10 quotient held", quotient, 14);
      check(remainder == 2, "R10 remainder held", remainder, 2);

      for (int i = 0; i < 200; i++) begin
         logic [W-1:0] a, b;
         bit sm, fm;
         a = $urandom;
         b = $urandom;
         if (i % 4 == 1) b = b >> (b[4:0]);
         if (i % 9 == 2) b = '0;
         sm = i[0];
         fm = i[1];
         issue(a, b, sm, fm, sm ? (fm ? "R5" : "R4") : "R3");
      end
      drain();

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule